// File: doc/BRIEF.md
# Restartable Byte String Engine

This block runs one of three string operations one byte at a time over a byte-wide memory port: copy a run of bytes from one place to another, fill a run of bytes from a rotating 32-bit pattern, or compare two runs of bytes and report the outcome as N, Z, V and C condition flags. A caller loads a byte count and two pointer-sized operands, selects the operation, and pulses `start`. The block then issues one memory request at a time and waits for each acknowledge.

The count and both operands are architectural state. They are brought out on the ports and updated after every completed byte. If an operation is cut short by `abort`, the caller can resume it later by reissuing the operation with the values read back. A compare stops at the first differing byte, with both pointers left on that byte and the count left at the number of bytes not yet matched. `done` pulses for one cycle when an operation ends for any reason.

Top module: `strop_engine`

## Requirements
- R1: While reset is held and after it is released, `cnt_out`, `ptr_a_out`, `ptr_b_out` and `flags_out` are zero, and `done`, `busy` and `mem_req` are low.
- R2: `op` is encoded as copy = 0, fill = 1, compare = 2 and no-op = 3. If `start` arrives with a count of zero, or with op 3, the block makes no memory access. The loaded values appear unchanged on the register outputs and `done` is high in the cycle after `start` is sampled.
- R3: Copy reads the byte at operand A and writes it to the address in operand B. After each byte it decrements the count and increments both pointers, and it continues while the count is non-zero.
- R4: Fill writes bits [7:0] of operand B to the address in operand A. After each byte it decrements the count, increments operand A and rotates operand B right by 8 bits.
- R5: At start, compare sets `flags_out` = {N,Z,V,C} = 4'b0100. If all counted bytes match, the flags stay at that value, the count ends at zero and both pointers have advanced by the original count.
- R6: On the first byte pair x (read through A) and y (read through B) with x != y, compare loads the flags from the 32-bit subtraction x - y of the zero-extended bytes. N is the sign of the difference, Z means equal, C means x < y unsigned, and V follows the signed overflow rule for subtraction. It then ends without changing the count or the pointers.
- R7: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` held stable until `mem_ack` is sampled high. Exactly one access completes per acknowledge.
- R8: An `abort` pulse while busy lets the byte in progress complete, including its register update, and then ends the operation with `done`.
- R9: `done` is a single-cycle pulse per operation, and `busy` is high from the accepted `start` until the cycle in which `done` is high.
- R10: A `start` pulse seen while busy is ignored and does not disturb the operation in progress.
- R11: Pointers wrap modulo 2^32, so the byte after address 0xFFFFFFFF is address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | Operation: 0 copy, 1 fill, 2 compare, 3 no-op |
| cnt_in | input | CNT_W | Byte count to load |
| ptr_a_in | input | ADDR_W | Operand A to load (source or fill target) |
| ptr_b_in | input | ADDR_W | Operand B to load (destination, pattern or compare string) |
| abort | input | 1 | Stop after the byte in progress |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| cnt_out | output | CNT_W | Current byte count |
| ptr_a_out | output | ADDR_W | Current operand A |
| ptr_b_out | output | ADDR_W | Current operand B |
| flags_out | output | 4 | Compare flags {N,Z,V,C} |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |

## Verification
The bench builds the block with its default parameters: a 32-bit count, 32-bit pointers and a byte lane of 8 bits. These widths let the pattern rotation cover four distinct bytes, and they let a pointer started at 0xFFFFFFFE cross the 2^32 boundary in two steps. The memory model decodes only the low 10 address bits, so wrapped addresses land in a small, fully checked array. The acknowledge latency ranges from zero to three cycles, which exercises both back-to-back requests and held requests.

// File: rtl/strop_pkg.sv
package strop_pkg;

    typedef enum logic [1:0] {
        OP_COPY = 2'd0,
        OP_FILL = 2'd1,
        OP_CMP  = 2'd2,
        OP_NONE = 2'd3
    } strop_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDA,
        ST_RDB,
        ST_WR,
        ST_FIN
    } strop_st_e;

    // flag vector layout {N,Z,V,C}
    localparam logic [3:0] FLAGS_EQUAL = 4'b0100;

endpackage

// File: rtl/strop_flags.sv
module strop_flags #(
    parameter int W = 32
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [3:0]   nzvc
);
    logic [W-1:0] diff;
    logic         ovf;

    always_comb begin
        diff = minuend - subtrahend;
        if (subtrahend[W-1])
            ovf = $signed(diff) < $signed(minuend);
        else
            ovf = $signed(diff) > $signed(minuend);
        nzvc = {diff[W-1], minuend == subtrahend, ovf, minuend < subtrahend};
    end
endmodule

// File: rtl/strop_step.sv
module strop_step #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              rotate,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] pa,
    input  logic [ADDR_W-1:0] pb,
    output logic [CNT_W-1:0]  cnt_nx,
    output logic [ADDR_W-1:0] pa_nx,
    output logic [ADDR_W-1:0] pb_nx,
    output logic              last
);
    logic [ADDR_W-1:0] pb_rot;

    generate
        if (ADDR_W > BYTE_W) begin : g_rot
            assign pb_rot = {pb[BYTE_W-1:0], pb[ADDR_W-1:BYTE_W]};
        end else begin : g_norot
            assign pb_rot = pb;
        end
    endgenerate

    always_comb begin
        cnt_nx = cnt - 1'b1;
        pa_nx  = pa + 1'b1;
        pb_nx  = rotate ? pb_rot : pb + 1'b1;
        last   = (cnt_nx == '0);
    end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
    import strop_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [ADDR_W-1:0] ptr_a_in,
    input  logic [ADDR_W-1:0] ptr_b_in,
    input  logic              abort,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [ADDR_W-1:0] ptr_a_out,
    output logic [ADDR_W-1:0] ptr_b_out,
    output logic [3:0]        flags_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int PAD_W = ADDR_W - BYTE_W;

    typedef struct packed {
        strop_st_e         st;
        strop_op_e         op;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] pa;
        logic [ADDR_W-1:0] pb;
        logic [BYTE_W-1:0] data;
        logic [3:0]        flags;
        logic              abort_p;
    } regs_t;

    regs_t q, d;

    logic [CNT_W-1:0]  cnt_nx;
    logic [ADDR_W-1:0] pa_nx, pb_nx;
    logic              last;
    logic [3:0]        cmp_nzvc;
    logic              in_xfer;

    strop_step #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_step (
        .rotate (q.op == OP_FILL),
        .cnt    (q.cnt),
        .pa     (q.pa),
        .pb     (q.pb),
        .cnt_nx (cnt_nx),
        .pa_nx  (pa_nx),
        .pb_nx  (pb_nx),
        .last   (last)
    );

    strop_flags #(.W(ADDR_W)) u_flags (
        .minuend    ({{PAD_W{1'b0}}, q.data}),
        .subtrahend ({{PAD_W{1'b0}}, mem_rdata}),
        .nzvc       (cmp_nzvc)
    );

    assign in_xfer = (q.st == ST_RDA) || (q.st == ST_RDB) || (q.st == ST_WR);

    always_comb begin
        d = q;
        if (in_xfer && abort)
            d.abort_p = 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.op      = strop_op_e'(op);
                    d.cnt     = cnt_in;
                    d.pa      = ptr_a_in;
                    d.pb      = ptr_b_in;
                    d.abort_p = 1'b0;
                    if (strop_op_e'(op) == OP_CMP)
                        d.flags = FLAGS_EQUAL;
                    if (cnt_in == '0 || strop_op_e'(op) == OP_NONE)
                        d.st = ST_FIN;
                    else if (strop_op_e'(op) == OP_FILL)
                        d.st = ST_WR;
                    else
                        d.st = ST_RDA;
                end
            end
            ST_RDA: begin
                if (mem_ack) begin
                    d.data = mem_rdata;
                    d.st   = (q.op == OP_CMP) ? ST_RDB : ST_WR;
                end
            end
            ST_RDB, ST_WR: begin
                if (mem_ack) begin
                    if (q.st == ST_RDB && mem_rdata != q.data) begin
                        d.flags = cmp_nzvc;
                        d.st    = ST_FIN;
                    end else begin
                        d.cnt = cnt_nx;
                        d.pa  = pa_nx;
                        d.pb  = pb_nx;
                        if (last || q.abort_p || abort)
                            d.st = ST_FIN;
                        else
                            d.st = (q.op == OP_FILL) ? ST_WR : ST_RDA;
                    end
                end
            end
            ST_FIN:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.op      <= OP_NONE;
            q.cnt     <= '0;
            q.pa      <= '0;
            q.pb      <= '0;
            q.data    <= '0;
            q.flags   <= '0;
            q.abort_p <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = (q.st == ST_FIN);
    assign cnt_out   = q.cnt;
    assign ptr_a_out = q.pa;
    assign ptr_b_out = q.pb;
    assign flags_out = q.flags;
    assign mem_req   = in_xfer;
    assign mem_we    = (q.st == ST_WR);
    assign mem_addr  = (q.st == ST_RDB || (q.st == ST_WR && q.op == OP_COPY)) ? q.pb : q.pa;
    assign mem_wdata = (q.op == OP_FILL) ? q.pb[BYTE_W-1:0] : q.data;

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start && cnt_in == '0) |=> (done && !mem_req));

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q.op == OP_CMP) |-> !mem_we);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt_out == $past(cnt_out) || cnt_out == $past(cnt_out) - 1'b1));

endmodule

// File: tb/sim_strop_engine.sv
module sim_strop_engine;
    localparam int MEMSZ = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] cnt_in = '0, ptr_a_in = '0, ptr_b_in = '0;
    logic        abort = 1'b0;
    logic        busy, done;
    logic [31:0] cnt_out, ptr_a_out, ptr_b_out;
    logic [3:0]  flags_out;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    strop_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cnt_in(cnt_in),
        .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in), .abort(abort), .busy(busy),
        .done(done), .cnt_out(cnt_out), .ptr_a_out(ptr_a_out), .ptr_b_out(ptr_b_out),
        .flags_out(flags_out), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int vectors = 0;
    int misses  = 0;

    typedef struct {
        logic [31:0] cnt;
        logic [31:0] pa;
        logic [31:0] pb;
        logic [3:0]  flags;
        string       rq;
    } exp_t;

    exp_t sb[$];

    logic [7:0] mem [MEMSZ];
    logic [7:0] refm[MEMSZ];
    int   lat = 0;
    int   wcnt = 0;
    int   acc = 0;
    int   done_cnt = 0;
    logic [31:0] held_addr = '0;
    logic [3:0]  mflags = 4'b0000;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt == 0) held_addr = mem_addr;
            if (wcnt >= lat) begin
                chk(mem_addr == held_addr, "R7", mem_addr, held_addr);
                mem_ack = 1'b1;
                acc++;
                if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[9:0]];
            end else begin
                wcnt++;
            end
        end
    end

    // scoreboard monitor
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                exp_t e;
                chk(!prev_done, "R9", 32'(prev_done), 32'd0);
                chk(busy, "R9", 32'(busy), 32'd1);
                if (sb.size() == 0) begin
                    chk(1'b0, "R9", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    chk(cnt_out == e.cnt, e.rq, cnt_out, e.cnt);
                    chk(ptr_a_out == e.pa, e.rq, ptr_a_out, e.pa);
                    chk(ptr_b_out == e.pb, e.rq, ptr_b_out, e.pb);
                    chk(flags_out == e.flags, e.rq, 32'(flags_out), 32'(e.flags));
                end
                done_cnt++;
            end
            prev_done = done;
        end
    end

    function automatic logic [3:0] sub_flags(input logic [7:0] x, input logic [7:0] y);
        logic [31:0] a, b, df;
        logic v;
        a  = {24'd0, x};
        b  = {24'd0, y};
        df = a - b;
        v  = b[31] ? ($signed(df) < $signed(a)) : ($signed(df) > $signed(a));
        return {df[31], a == b, v, a < b};
    endfunction

    task automatic poke(input int addr, input logic [7:0] val);
        mem[addr] = val;
        refm[addr] = val;
    endtask

    task automatic run_op(input logic [1:0] o, input logic [31:0] n, input logic [31:0] a,
                          input logic [31:0] b, input bit do_abort, input bit do_poke,
                          input string rq);
        exp_t e;
        int limit, nacc, d0;
        logic [7:0] x, y;
        e.cnt = n; e.pa = a; e.pb = b; e.rq = rq;
        nacc = 0;
        if (o == 2'd2) mflags = 4'b0100;
        limit = (o == 2'd3) ? 0 : (do_abort && n > 0) ? 1 : int'(n);
        for (int i = 0; i < limit; i++) begin
            if (o == 2'd0) begin
                refm[e.pb[9:0]] = refm[e.pa[9:0]];
                e.pb = e.pb + 1; nacc += 2;
            end else if (o == 2'd1) begin
                refm[e.pa[9:0]] = e.pb[7:0];
                e.pb = {e.pb[7:0], e.pb[31:8]}; nacc += 1;
            end else begin
                x = refm[e.pa[9:0]]; y = refm[e.pb[9:0]]; nacc += 2;
                if (x != y) begin
                    mflags = sub_flags(x, y);
                    break;
                end
                e.pb = e.pb + 1;
            end
            e.pa  = e.pa + 1;
            e.cnt = e.cnt - 1;
        end
        e.flags = mflags;
        sb.push_back(e);
        acc = 0;
        d0 = done_cnt;
        @(negedge clk);
        start = 1'b1; op = o; cnt_in = n; ptr_a_in = a; ptr_b_in = b;
        @(negedge clk);
        start = 1'b0;
        if (do_abort) begin
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
        end
        if (do_poke) begin
            start = 1'b1; op = 2'd1; cnt_in = 32'd9; ptr_a_in = 32'h3F0; ptr_b_in = 32'hDEADBEEF;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
        chk(acc == nacc, rq, acc, nacc);
        begin
            int bad = 0;
            for (int i = 0; i < MEMSZ; i++) if (mem[i] != refm[i]) bad++;
            chk(bad == 0, rq, bad, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i]  = 8'(i * 37 + 11);
            refm[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cnt_out == 0 && ptr_a_out == 0 && ptr_b_out == 0 && flags_out == 0 &&
            !done && !busy && !mem_req, "R1", {cnt_out[15:0], 12'd0, flags_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && cnt_out == 0, "R1", 32'(busy), 32'd0);

        // R3: copy, zero and two-cycle latency
        lat = 0; run_op(2'd0, 32'd6, 32'h010, 32'h210, 0, 0, "R3");
        lat = 2; run_op(2'd0, 32'd5, 32'h040, 32'h240, 0, 0, "R3");
        // R4: fill with rotating pattern
        lat = 1; run_op(2'd1, 32'd7, 32'h100, 32'h44332211, 0, 0, "R4");
        // R5: compare equal (region copied above)
        lat = 0; run_op(2'd2, 32'd6, 32'h010, 32'h210, 0, 0, "R5");
        // R6: mismatch at position 3, first byte larger
        for (int i = 0; i < 8; i++) begin poke(32'h300 + i, 8'(i + 5)); poke(32'h340 + i, 8'(i + 5)); end
        poke(32'h303, 8'hC0); poke(32'h343, 8'h10);
        lat = 3; run_op(2'd2, 32'd8, 32'h300, 32'h340, 0, 0, "R6");
        // R6: mismatch, first byte smaller
        poke(32'h305, 8'h01); poke(32'h345, 8'hF0);
        lat = 0; run_op(2'd2, 32'd3, 32'h304, 32'h344, 0, 0, "R6");
        // R2: zero count and no-op opcode
        run_op(2'd0, 32'd0, 32'h050, 32'h250, 0, 0, "R2");
        run_op(2'd3, 32'd4, 32'h060, 32'h260, 0, 0, "R2");
        // R8: abort during copy and during fill
        lat = 1; run_op(2'd0, 32'd5, 32'h070, 32'h270, 1, 0, "R8");
        lat = 0; run_op(2'd1, 32'd6, 32'h120, 32'hA1B2C3D4, 1, 0, "R8");
        // R10: start pulse while busy is ignored
        lat = 1; run_op(2'd0, 32'd6, 32'h080, 32'h280, 0, 1, "R10");
        // R11: pointer wraps across 2^32
        lat = 0; run_op(2'd0, 32'd3, 32'hFFFF_FFFE, 32'h0000_0180, 0, 0, "R11");
        chk(sb.size() == 0, "R9", sb.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule